// File: doc/BRIEF.md
# Redundant Pipeline Digit Combiner

This block takes the sub-converter decisions of a six-stage pipelined analog-to-digital converter and forms one 12-bit output word for each sample. Every stage resolves ten levels with nine comparators, which gives a thermometer code. From one stage to the next the residue is amplified by four. Because the stage digits overlap, a decision error in one stage is corrected by the stages after it, as long as the residue stays in range. In the first stage all nine comparators are real. In every later stage the outermost two decisions are hard-wired: the lowest is treated as high and the highest as low.

The analog pipeline delivers the decisions of one sample with a skew. Stage k decides k accepted cycles after stage 0. The block decodes each code to a digit and flags codes that are not proper thermometer codes. It delays each stage so that all six digits of a sample meet in the same cycle. It then sums them with weights 4^(5-k), scales the result and clamps it to the 12-bit range. A sample-valid strobe travels with stage 0.

The output side is valid/ready. When the output holds a valid word and the consumer withholds ready, the whole pipeline freezes and `in_ready` drops. The producer must then hold `in_therm` and `in_valid` until `in_ready` returns. When no valid word is waiting, the pipeline keeps advancing whatever the state of `out_ready`.

Top module: `pipe_redundant_combine`

## Requirements
- R1: Stage k's code occupies `in_therm[9k+8:9k]`, with bit 9k the lowest threshold. The stage digit is the number of bits that are 1 in the code after the tie-offs of R2 are applied.
- R2: For stages 1 to 5, input bits 9k and 9k+8 have no effect. They are taken as 1 and 0, so those digits fall in the range 1 to 8.
- R3: With digits d_k, S = sum over k of (2*d_k - 9) * 4^(5-k), and `out_code` = floor((S + 4096) / 2).
- R4: A result below 0 is output as 0, and a result above 4095 is output as 4095. In both cases `out_clip` is 1 for that word; otherwise it is 0.
- R5: Stage k's code, given k accepted cycles after stage 0's code of the same sample, joins that sample. The word appears 7 accepted cycles after stage 0's code is accepted (an accepted cycle is one with `in_ready` high at the clock edge).
- R6: A code after tie-offs that has a 0 below a 1 still decodes by its count of ones. It sets `out_bubble` on the word of that sample.
- R7: `err_sticky` goes to 1 together with the first valid word that has `out_bubble` set. It stays 1 until reset.
- R8: `out_valid` repeats `in_valid` of stage 0 with the latency of R5, so it is 0 for the first 7 cycles after reset. `out_clip` and `out_bubble` are 0 whenever `out_valid` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold their values. Otherwise `in_ready` is 1.
- R10: After reset, `out_valid`, `out_code`, `out_clip`, `out_bubble` and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stage 0's code in this cycle belongs to a valid sample |
| in_ready | output | 1 | Inputs are taken at this clock edge |
| in_therm | input | 54 | Thermometer codes of all six stages, stage k at bits 9k+8 to 9k |
| out_valid | output | 1 | Output word holds a valid sample |
| out_ready | input | 1 | Consumer accepts the output word |
| out_code | output | 12 | Corrected unsigned output word |
| out_clip | output | 1 | Word was clamped to a rail |
| out_bubble | output | 1 | A stage code of this sample was not a proper thermometer code |
| err_sticky | output | 1 | A bubble has been seen since reset |

## Verification
The bench feeds samples with the same stage skew the analog pipeline produces. A design that aligned a stage one cycle off would mix the digits of neighbouring samples and give wrong words. Later stages are driven with their outer bits inverted: a design that used those bits would shift the result and raise false bubbles. Extreme digit sets push the sum past both rails, which catches a wrap where the word should clamp. A stall with a valid word held checks that nothing moves and no skew is lost. Valid gaps and deliberate bubbles confirm that the flags follow the right sample and that the error bit stays set.

// File: rtl/dcorr_pkg.sv
package dcorr_pkg;
  localparam int unsigned DC_STAGES    = 6;
  localparam int unsigned DC_COMPS     = 9;
  localparam int unsigned DC_GAIN_LOG2 = 2;
  localparam int unsigned DC_OUT_W     = 12;
endpackage

// File: rtl/therm_decode.sv
module therm_decode #(
  parameter int unsigned COMPS    = 9,
  parameter int unsigned DW       = 4,
  parameter bit          TIE_ENDS = 1'b0
) (
  input  logic [COMPS-1:0] code_in,
  output logic [DW-1:0]    digit,
  output logic             bubble
);
  logic [COMPS-1:0] code_eff;

  generate
    if (TIE_ENDS) begin : g_tied
      assign code_eff = {1'b0, code_in[COMPS-2:1], 1'b1};
    end else begin : g_free
      assign code_eff = code_in;
    end
  endgenerate

  always_comb begin
    digit = '0;
    for (int i = 0; i < COMPS; i++) begin
      digit = digit + DW'(code_eff[i]);
    end
  end

  // a rising edge going upward in the code means a 0 sits below a 1
  assign bubble = |(~code_eff[COMPS-2:0] & code_eff[COMPS-1:1]);
endmodule

// File: rtl/align_delay.sv
module align_delay #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [WIDTH-1:0] sr [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else if (en) begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/overlap_sum.sv
module overlap_sum #(
  parameter int unsigned STAGES    = 6,
  parameter int unsigned COMPS     = 9,
  parameter int unsigned DW        = 4,
  parameter int unsigned GAIN_LOG2 = 2,
  parameter int unsigned OUT_W     = 12,
  parameter int unsigned SW        = 18
) (
  input  logic [STAGES*DW-1:0] digits,
  output logic [OUT_W-1:0]     code,
  output logic                 clip
);
  localparam logic signed [SW-1:0] MID  = SW'(COMPS);
  localparam logic signed [SW-1:0] BIAS = SW'(2 ** OUT_W);
  localparam logic signed [SW-1:0] TOPV = SW'(2 ** OUT_W - 1);

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] half;
  logic signed [SW-1:0] term;

  always_comb begin
    acc  = '0;
    term = '0;
    for (int k = 0; k < STAGES; k++) begin
      term = SW'({digits[k*DW +: DW], 1'b0}) - MID;
      acc  = acc + (term <<< (GAIN_LOG2 * (STAGES - 1 - k)));
    end
    half = (acc + BIAS) >>> 1;
    if (half < 0) begin
      code = '0;
      clip = 1'b1;
    end else if (half > TOPV) begin
      code = '1;
      clip = 1'b1;
    end else begin
      code = half[OUT_W-1:0];
      clip = 1'b0;
    end
  end
endmodule

// File: rtl/pipe_redundant_combine.sv
module pipe_redundant_combine #(
  parameter int unsigned STAGES    = dcorr_pkg::DC_STAGES,
  parameter int unsigned COMPS     = dcorr_pkg::DC_COMPS,
  parameter int unsigned GAIN_LOG2 = dcorr_pkg::DC_GAIN_LOG2,
  parameter int unsigned OUT_W     = dcorr_pkg::DC_OUT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [STAGES*COMPS-1:0] in_therm,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [OUT_W-1:0]        out_code,
  output logic                    out_clip,
  output logic                    out_bubble,
  output logic                    err_sticky
);
  localparam int unsigned DW     = $clog2(COMPS + 1);
  localparam int unsigned SW_RAW = DW + GAIN_LOG2 * (STAGES - 1) + 4;
  localparam int unsigned SW     = (SW_RAW > OUT_W + 3) ? SW_RAW : OUT_W + 3;

  logic                 adv;
  logic [STAGES*DW-1:0] aligned_digits;
  logic [STAGES-1:0]    aligned_bub;
  logic                 v_dec;
  logic                 v_al;
  logic [OUT_W-1:0]     sum_code;
  logic                 sum_clip;

  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [DW-1:0] dig_c;
      logic          bub_c;
      logic [DW:0]   dec_q;
      logic [DW:0]   al_q;

      therm_decode #(
        .COMPS(COMPS), .DW(DW), .TIE_ENDS(k > 0)
      ) u_dec (
        .code_in(in_therm[k*COMPS +: COMPS]),
        .digit  (dig_c),
        .bubble (bub_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   dec_q <= '0;
        else if (adv) dec_q <= {bub_c, dig_c};
      end

      align_delay #(
        .WIDTH(DW + 1), .DEPTH(STAGES - 1 - k)
      ) u_dly (
        .clk(clk), .rst_n(rst_n), .en(adv), .d(dec_q), .q(al_q)
      );

      assign aligned_digits[k*DW +: DW] = al_q[DW-1:0];
      assign aligned_bub[k]             = al_q[DW];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   v_dec <= 1'b0;
    else if (adv) v_dec <= in_valid;
  end

  align_delay #(
    .WIDTH(1), .DEPTH(STAGES - 1)
  ) u_vdly (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(v_dec), .q(v_al)
  );

  overlap_sum #(
    .STAGES(STAGES), .COMPS(COMPS), .DW(DW),
    .GAIN_LOG2(GAIN_LOG2), .OUT_W(OUT_W), .SW(SW)
  ) u_sum (
    .digits(aligned_digits),
    .code  (sum_code),
    .clip  (sum_clip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_code   <= '0;
      out_clip   <= 1'b0;
      out_bubble <= 1'b0;
      err_sticky <= 1'b0;
    end else if (adv) begin
      out_valid  <= v_al;
      out_code   <= sum_code;
      out_clip   <= v_al & sum_clip;
      out_bubble <= v_al & (|aligned_bub);
      err_sticky <= err_sticky | (v_al & (|aligned_bub));
    end
  end
endmodule

// File: rtl/pipe_redundant_combine_chk.sv
module pipe_redundant_combine_chk #(
  parameter int unsigned STAGES = 6,
  parameter int unsigned OUT_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_code,
  input logic             out_clip,
  input logic             out_bubble,
  input logic             err_sticky
);
  localparam int unsigned LAT = STAGES + 1;
  localparam int unsigned CW  = $clog2(LAT + 1);
  localparam logic [OUT_W-1:0] MAXV = '1;

  logic [CW-1:0] fill_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_cnt <= '0;
    else if (fill_cnt < CW'(LAT)) fill_cnt <= fill_cnt + 1'b1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_clip) && $stable(out_bubble)); // R9

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R7

  AST_BUBBLE_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bubble |-> err_sticky); // R7

  AST_CLIP_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    out_clip |-> (out_code == '0 || out_code == MAXV)); // R4

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt < CW'(LAT) |-> !out_valid); // R8

  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_clip && !out_bubble); // R8
endmodule

bind pipe_redundant_combine pipe_redundant_combine_chk #(
  .STAGES(STAGES), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_code(out_code), .out_clip(out_clip), .out_bubble(out_bubble),
  .err_sticky(err_sticky)
);

// File: tb/pipe_redundant_combine_test.sv
module pipe_redundant_combine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [53:0] in_therm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_code;
  logic        out_clip;
  logic        out_bubble;
  logic        err_sticky;

  int nchecks = 0;
  int nerr = 0;
  bit exp_sticky = 1'b0;

  logic [8:0] codes [0:39][0:5];
  bit         vflag [0:39];

  always #2 clk = ~clk;

  pipe_redundant_combine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_therm(in_therm), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_clip(out_clip), .out_bubble(out_bubble),
    .err_sticky(err_sticky)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [8:0] therm(input int d);
    return 9'((1 << d) - 1);
  endfunction

  task automatic expect_word(input int idx, output int code, output bit clip,
                             output bit bub);
    int s = 0;
    bub = 1'b0;
    for (int k = 0; k < 6; k++) begin
      logic [8:0] c = codes[idx][k];
      int d;
      if (k > 0) begin
        c[0] = 1'b1;
        c[8] = 1'b0;
      end
      d = $countones(c);
      if (int'(c) != ((1 << d) - 1)) bub = 1'b1;
      s += (2 * d - 9) * (1 << (2 * (5 - k)));
    end
    code = (s + 4096) >>> 1;
    clip = 1'b0;
    if (code < 0) begin
      code = 0;
      clip = 1'b1;
    end else if (code > 4095) begin
      code = 4095;
      clip = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    in_therm = '0;
    exp_sticky = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill_pattern(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      vflag[i] = 1'b1;
      for (int k = 0; k < 6; k++) begin
        int d;
        if (k == 0) d = (i * 7 + seed) % 10;
        else        d = 1 + (i * 3 + k * 5 + seed) % 8;
        codes[i][k] = therm(d);
      end
    end
  endtask

  // drives n samples with stage skew; output seen at accepted count a holds sample a-7 (R5)
  task automatic run_seq(input int n, input int stall_at, input int stall_len,
                         input string rq);
    int a = 0;
    int stall_left = stall_len;
    int guard = 0;
    while (a < n + 8 && guard < 2000) begin
      int idx;
      bit ev;
      bit acc;
      guard++;
      @(negedge clk);
      idx = a - 7;
      ev = (idx >= 0 && idx < n) ? vflag[idx] : 1'b0;
      check(out_valid == ev, rq, "out_valid", int'(out_valid), int'(ev));
      if (ev) begin
        int ec;
        bit eclip, ebub;
        expect_word(idx, ec, eclip, ebub);
        check(out_code == 12'(ec), rq, "out_code", int'(out_code), ec);
        check(out_clip == eclip, rq, "out_clip", int'(out_clip), int'(eclip));
        check(out_bubble == ebub, rq, "out_bubble", int'(out_bubble), int'(ebub));
        exp_sticky |= ebub;
      end
      check(err_sticky == exp_sticky, rq, "err_sticky", int'(err_sticky), int'(exp_sticky));
      out_ready = 1'b1;
      if (a == stall_at && stall_left > 0) begin
        out_ready = 1'b0;
        stall_left--;
      end
      in_valid = (a < n) ? vflag[a] : 1'b0;
      for (int k = 0; k < 6; k++) begin
        int j = a - k;
        in_therm[k*9 +: 9] = (j >= 0 && j < n) ? codes[j][k] : 9'h155;
      end
      #1;
      if (!out_ready && out_valid)
        check(in_ready == 1'b0, "R9", "in_ready during stall", int'(in_ready), 0);
      acc = in_ready;
      @(posedge clk);
      if (acc) a++;
    end
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    out_ready = 1'b0;
    #1;
    check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    check(out_code == 12'd0, "R10", "out_code after reset", int'(out_code), 0);
    check(out_clip == 1'b0 && out_bubble == 1'b0, "R10", "flags after reset",
          int'({out_clip, out_bubble}), 0);
    check(err_sticky == 1'b0, "R10", "err_sticky after reset", int'(err_sticky), 0);
    check(in_ready == 1'b1, "R9", "in_ready with no word held", int'(in_ready), 1);
    out_ready = 1'b1;
  endtask

  task automatic test_mixed_digits();
    do_reset();
    fill_pattern(16, 1);
    run_seq(16, -1, 0, "R1 R3 R5");
  endtask

  task automatic test_outer_ignored();
    do_reset();
    fill_pattern(14, 4);
    for (int i = 0; i < 14; i++)
      for (int k = 1; k < 6; k++) begin
        codes[i][k][0] = 1'b0;
        codes[i][k][8] = 1'b1;
      end
    run_seq(14, -1, 0, "R2");
  endtask

  task automatic test_saturation();
    do_reset();
    for (int i = 0; i < 4; i++) vflag[i] = 1'b1;
    codes[0][0] = therm(9);
    for (int k = 1; k < 6; k++) codes[0][k] = therm(8);
    codes[1][0] = therm(0);
    for (int k = 1; k < 6; k++) codes[1][k] = therm(1);
    codes[2][0] = therm(5);
    for (int k = 1; k < 6; k++) codes[2][k] = therm(4);
    codes[3][0] = therm(6);
    codes[3][1] = therm(6);
    codes[3][2] = therm(5);
    codes[3][3] = therm(7);
    codes[3][4] = therm(8);
    codes[3][5] = therm(8);
    run_seq(4, -1, 0, "R4");
  endtask

  task automatic test_bubble_sticky();
    do_reset();
    fill_pattern(12, 2);
    codes[4][3] = 9'b0_0001_1011;
    codes[7][0] = 9'b1_0000_0000;
    run_seq(12, -1, 0, "R6 R7");
    #1;
    check(err_sticky == 1'b1, "R7", "err_sticky after idle", int'(err_sticky), 1);
  endtask

  task automatic test_valid_gaps();
    do_reset();
    fill_pattern(15, 3);
    for (int i = 0; i < 15; i++) vflag[i] = (i % 3 != 1);
    run_seq(15, -1, 0, "R8");
  endtask

  task automatic test_backpressure();
    do_reset();
    fill_pattern(16, 5);
    run_seq(16, 10, 4, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    test_reset();
    test_mixed_digits();
    test_outer_ignored();
    test_saturation();
    test_bubble_sticky();
    test_valid_gaps();
    test_backpressure();
    $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule